// File: doc/BRIEF.md
# Event Interrupt Status Controller

This block collects single-cycle event pulses from a four-context transfer engine and turns them into one level-sensitive interrupt. Each context reports three kinds of event: a completed context, an invalid access, and a read that arrived before enough data had been prefetched (an underrun). Two engine-wide events come on top: an access outside the translated address window, and an error returned by the downstream bus. Every event latches into a raw status vector, whether or not it is enabled. An enable mask selects which latched events may raise the interrupt line.

Software sees four 32-bit registers through a simple synchronous write port and a combinational read port:
- The raw view at offset 0x20 accepts write-1-to-set, so events can be injected for debug.
- The enabled view at offset 0x24 reads as raw AND mask. Writing 1 to a bit there clears the raw bit.
- The mask has a set window at 0x28 and a clear window at 0x2C. Both read back the mask.

Top module: `irq_status_ctl`

## Requirements
- R1: An event pulse sets its raw status bit at the next clock edge, whatever the state of its mask bit.
- R2: Writing offset 0x20 sets every raw bit written as 1. Bits written as 0 keep their value.
- R3: Reading offset 0x24 returns raw status AND enable mask.
- R4: Writing 1 to a bit at offset 0x24 clears that raw bit, even when the bit is not enabled.
- R5: Writing 1 at offset 0x28 sets mask bits and writing 1 at offset 0x2C clears mask bits. Both offsets read back the current mask.
- R6: Bit positions are the same in all four registers:
  - bit 0: bus error;
  - bit 1: window invalid access;
  - bits 8..11: completion of contexts 0..3;
  - bits 16..19: invalid access of contexts 0..3;
  - bits 24..27: underrun of contexts 0..3.
  
  All other bits read as 0 and cannot be set.
- R7: Only offsets 0x20, 0x24, 0x28 and 0x2C are decoded. Any other offset reads as 0, and a write to it changes no state.
- R8: `irq_o` is a register. It is 1 exactly when raw AND mask was nonzero in the previous cycle.
- R9: When an event and a write-1-to-clear of the same bit occur in the same cycle, the bit stays set.
- R10: Synchronous reset clears all raw bits, all mask bits and `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_bus_err | input | 1 | Pulse: error response from the downstream bus |
| ev_win_invalid | input | 1 | Pulse: access outside the translated window |
| ev_ctx_done | input | NUM_CTX | Pulse per context: context completed |
| ev_ctx_invalid | input | NUM_CTX | Pulse per context: invalid access |
| ev_ctx_underrun | input | NUM_CTX | Pulse per context: read before data was prefetched |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_o | output | 1 | Level interrupt |

## Verification
A raw or mask bit in the wrong state can be seen on `reg_rdata` as soon as the matching offset is addressed, with no delay after the edge that stored it. The same fault reaches `irq_o` one cycle later. The bench therefore reads a register back after every step, and checks the interrupt level at that same point. This exposes the following faults within one or two cycles:
- lost events;
- a clear that beats a simultaneous event;
- reserved bits that can be set;
- a swapped field position;
- a mask that differs between the set and clear windows.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int DATA_W   = 32;
    localparam int CTX_N    = 4;
    localparam int ADDR_W_D = 8;

    // field positions, shared by all four registers
    localparam int BUS_ERR_BIT  = 0;
    localparam int WIN_INV_BIT  = 1;
    localparam int DONE_LSB     = 8;
    localparam int CTX_INV_LSB  = 16;
    localparam int UNDERRUN_LSB = 24;

    // register offsets
    localparam logic [ADDR_W_D-1:0] OFF_RAW  = 8'h20;
    localparam logic [ADDR_W_D-1:0] OFF_ENA  = 8'h24;
    localparam logic [ADDR_W_D-1:0] OFF_MSET = 8'h28;
    localparam logic [ADDR_W_D-1:0] OFF_MCLR = 8'h2C;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [2:0] {
        SEL_RAW,
        SEL_ENA,
        SEL_MSET,
        SEL_MCLR,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        word_t raw_set;
        word_t raw_clr;
        word_t msk_set;
        word_t msk_clr;
    } wr_cmd_t;

    function automatic word_t valid_mask(input int n_ctx);
        word_t m;
        m = '0;
        m[BUS_ERR_BIT] = 1'b1;
        m[WIN_INV_BIT] = 1'b1;
        for (int c = 0; c < n_ctx; c++) begin
            m[DONE_LSB + c]     = 1'b1;
            m[CTX_INV_LSB + c]  = 1'b1;
            m[UNDERRUN_LSB + c] = 1'b1;
        end
        return m;
    endfunction

    localparam word_t VALID_BITS = valid_mask(CTX_N);

endpackage

// File: rtl/irq_ev_map.sv
module irq_ev_map
    import irq_ctl_pkg::*;
#(
    parameter int NUM_CTX = CTX_N
) (
    input  logic               bus_err,
    input  logic               win_invalid,
    input  logic [NUM_CTX-1:0] ctx_done,
    input  logic [NUM_CTX-1:0] ctx_invalid,
    input  logic [NUM_CTX-1:0] ctx_underrun,
    output word_t              ev_vec
);

    always_comb begin
        ev_vec              = '0;
        ev_vec[BUS_ERR_BIT] = bus_err;
        ev_vec[WIN_INV_BIT] = win_invalid;
        for (int c = 0; c < NUM_CTX; c++) begin
            ev_vec[DONE_LSB + c]     = ctx_done[c];
            ev_vec[CTX_INV_LSB + c]  = ctx_invalid[c];
            ev_vec[UNDERRUN_LSB + c] = ctx_underrun[c];
        end
    end

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_ctl_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_D
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    input  word_t             raw_q,
    input  word_t             ena_vec,
    input  word_t             msk_q,
    output wr_cmd_t           cmd,
    output word_t             rdata
);

    reg_sel_e sel;
    word_t    wmask;

    always_comb begin
        if (addr == ADDR_W'(OFF_RAW))       sel = SEL_RAW;
        else if (addr == ADDR_W'(OFF_ENA))  sel = SEL_ENA;
        else if (addr == ADDR_W'(OFF_MSET)) sel = SEL_MSET;
        else if (addr == ADDR_W'(OFF_MCLR)) sel = SEL_MCLR;
        else                                sel = SEL_NONE;
    end

    assign wmask = wr ? (wdata & VALID_BITS) : '0;

    always_comb begin
        cmd = '0;
        unique case (sel)
            SEL_RAW:  cmd.raw_set = wmask;
            SEL_ENA:  cmd.raw_clr = wmask;
            SEL_MSET: cmd.msk_set = wmask;
            SEL_MCLR: cmd.msk_clr = wmask;
            default:  cmd = '0;
        endcase
    end

    always_comb begin
        unique case (sel)
            SEL_RAW:            rdata = raw_q;
            SEL_ENA:            rdata = ena_vec;
            SEL_MSET, SEL_MCLR: rdata = msk_q;
            default:            rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_stat_bank.sv
module irq_stat_bank
    import irq_ctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  word_t   ev_vec,
    input  wr_cmd_t cmd,
    output word_t   raw_q,
    output word_t   msk_q,
    output word_t   ena_vec
);

    word_t raw_d;
    word_t msk_d;

    // events are ORed in after the clear, so they win (R9)
    always_comb begin
        raw_d = ((raw_q & ~cmd.raw_clr) | cmd.raw_set | ev_vec) & VALID_BITS;
        msk_d = ((msk_q | cmd.msk_set) & ~cmd.msk_clr) & VALID_BITS;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= '0;
            msk_q <= '0;
        end else begin
            raw_q <= raw_d;
            msk_q <= msk_d;
        end
    end

    assign ena_vec = raw_q & msk_q;

    // R1
    ev_sets_raw_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_vec != '0) |=> ((raw_q & $past(ev_vec & VALID_BITS)) == $past(ev_vec & VALID_BITS)));

    // R6
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((raw_q & ~VALID_BITS) == '0) && ((msk_q & ~VALID_BITS) == '0));

    // R4
    clr_raw_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.raw_clr != '0) |=> ((raw_q & $past(cmd.raw_clr & ~ev_vec)) == '0));

    // R5
    msk_set_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.msk_set != '0) |=> ((msk_q & $past(cmd.msk_set)) == $past(cmd.msk_set)));

    // R5
    msk_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.msk_clr != '0) |=> ((msk_q & $past(cmd.msk_clr)) == '0));

    // R2
    raw_set_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.raw_set != '0) |=> ((raw_q & $past(cmd.raw_set)) == $past(cmd.raw_set)));

endmodule

// File: rtl/irq_status_ctl.sv
module irq_status_ctl
    import irq_ctl_pkg::*;
#(
    parameter int NUM_CTX = CTX_N,
    parameter int ADDR_W  = ADDR_W_D
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ev_bus_err,
    input  logic               ev_win_invalid,
    input  logic [NUM_CTX-1:0] ev_ctx_done,
    input  logic [NUM_CTX-1:0] ev_ctx_invalid,
    input  logic [NUM_CTX-1:0] ev_ctx_underrun,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq_o
);

    word_t   ev_vec;
    word_t   raw_q;
    word_t   msk_q;
    word_t   ena_vec;
    wr_cmd_t cmd;

    irq_ev_map #(.NUM_CTX(NUM_CTX)) ev_map_i (
        .bus_err      (ev_bus_err),
        .win_invalid  (ev_win_invalid),
        .ctx_done     (ev_ctx_done),
        .ctx_invalid  (ev_ctx_invalid),
        .ctx_underrun (ev_ctx_underrun),
        .ev_vec       (ev_vec)
    );

    irq_reg_port #(.ADDR_W(ADDR_W)) port_i (
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .raw_q   (raw_q),
        .ena_vec (ena_vec),
        .msk_q   (msk_q),
        .cmd     (cmd),
        .rdata   (reg_rdata)
    );

    irq_stat_bank bank_i (
        .clk     (clk),
        .rst     (rst),
        .ev_vec  (ev_vec),
        .cmd     (cmd),
        .raw_q   (raw_q),
        .msk_q   (msk_q),
        .ena_vec (ena_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= |ena_vec;
    end

    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(ena_vec != '0));

    // R8
    irq_low_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_o |-> $past(ena_vec == '0));

    // R10
    rst_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!irq_o && raw_q == '0 && msk_q == '0));

endmodule

// File: tb/irq_status_ctl_tb.sv
module irq_status_ctl_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [13:0] ev;     // {underrun[3:0], ctx_inv[3:0], done[3:0], win_inv, bus_err}
        logic [7:0]  chk;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h00, 32'h0,         14'h0001, 8'h20, 32'h0000_0001, 1'b0, 4'd1},  // R1 event without enable
        '{1'b0, 8'h00, 32'h0,         14'h0000, 8'h24, 32'h0000_0000, 1'b0, 4'd3},  // R3 masked view
        '{1'b1, 8'h28, 32'h0000_0001, 14'h0000, 8'h2C, 32'h0000_0001, 1'b0, 4'd5},  // R5 set, read via clr
        '{1'b0, 8'h00, 32'h0,         14'h0000, 8'h24, 32'h0000_0001, 1'b1, 4'd8},  // R8 irq one cycle later
        '{1'b1, 8'h20, 32'hFFFF_FFFF, 14'h0000, 8'h20, 32'h0F0F_0F03, 1'b1, 4'd2},  // R2 inject, R6 reserved
        '{1'b1, 8'h24, 32'h0F0F_0F02, 14'h0000, 8'h20, 32'h0000_0001, 1'b1, 4'd4},  // R4 clear unenabled
        '{1'b1, 8'h2C, 32'h0000_0001, 14'h0000, 8'h28, 32'h0000_0000, 1'b1, 4'd5},  // R5 clear, read via set
        '{1'b0, 8'h00, 32'h0,         14'h0000, 8'h24, 32'h0000_0000, 1'b0, 4'd8},  // R8 drop
        '{1'b1, 8'h24, 32'h0000_0001, 14'h0000, 8'h20, 32'h0000_0000, 1'b0, 4'd4},  // R4
        '{1'b1, 8'h28, 32'h0F00_0000, 14'h1000, 8'h24, 32'h0400_0000, 1'b0, 4'd6},  // R6 underrun ctx2 bit 26
        '{1'b0, 8'h00, 32'h0,         14'h0000, 8'h20, 32'h0400_0000, 1'b1, 4'd8},  // R8
        '{1'b1, 8'h24, 32'h0400_0000, 14'h1000, 8'h20, 32'h0400_0000, 1'b1, 4'd9},  // R9 event wins
        '{1'b1, 8'h24, 32'h0400_0000, 14'h0000, 8'h20, 32'h0000_0000, 1'b1, 4'd4},  // R4
        '{1'b0, 8'h00, 32'h0,         14'h0000, 8'h24, 32'h0000_0000, 1'b0, 4'd8},  // R8
        '{1'b0, 8'h00, 32'h0,         14'h3FFF, 8'h20, 32'h0F0F_0F03, 1'b0, 4'd6},  // R6 all events
        '{1'b0, 8'h00, 32'h0,         14'h0000, 8'h24, 32'h0F00_0000, 1'b1, 4'd3},  // R3
        '{1'b1, 8'h30, 32'hFFFF_FFFF, 14'h0000, 8'h30, 32'h0000_0000, 1'b1, 4'd7},  // R7 undecoded
        '{1'b0, 8'h00, 32'h0,         14'h0000, 8'h28, 32'h0F00_0000, 1'b1, 4'd7},  // R7 no state change
        '{1'b1, 8'h28, 32'hFFFF_FFFF, 14'h0000, 8'h2C, 32'h0F0F_0F03, 1'b1, 4'd6},  // R6 mask reserved
        '{1'b1, 8'h24, 32'hFFFF_FFFF, 14'h0000, 8'h24, 32'h0000_0000, 1'b1, 4'd4},  // R4 clear all
        '{1'b0, 8'h00, 32'h0,         14'h0208, 8'h24, 32'h0008_0200, 1'b0, 4'd6},  // R6 done1 bit9, inv3 bit19
        '{1'b0, 8'h00, 32'h0,         14'h0000, 8'h20, 32'h0008_0200, 1'b1, 4'd8}   // R8
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        ev_bus_err, ev_win_invalid;
    logic [3:0]  ev_ctx_done, ev_ctx_invalid, ev_ctx_underrun;
    logic        reg_wr;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_ctl dut_i (
        .clk(clk), .rst(rst),
        .ev_bus_err(ev_bus_err), .ev_win_invalid(ev_win_invalid),
        .ev_ctx_done(ev_ctx_done), .ev_ctx_invalid(ev_ctx_invalid),
        .ev_ctx_underrun(ev_ctx_underrun),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic drive_ev(input logic [13:0] ev);
        ev_bus_err      = ev[0];
        ev_win_invalid  = ev[1];
        ev_ctx_done     = ev[5:2];
        ev_ctx_invalid  = ev[9:6];
        ev_ctx_underrun = ev[13:10];
    endtask

    task automatic check_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s: rdata@%02h = %08h, expected %08h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic check_irq(input logic exp, input string tag);
        checks++;
        if (irq_o !== exp) begin
            errors++;
            $display("FAIL %s: irq_o = %0b, expected %0b", tag, irq_o, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        checks++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        reg_wr = 1'b0;
        reg_addr = 8'h00;
        reg_wdata = '0;
        drive_ev(14'h0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R10 reset state
        check_rd(8'h20, 32'h0, "R10 raw");
        check_rd(8'h28, 32'h0, "R10 mask");
        check_irq(1'b0, "R10 irq");

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            reg_wr    = VECS[i].wr;
            reg_addr  = VECS[i].addr;
            reg_wdata = VECS[i].wdata;
            drive_ev(VECS[i].ev);
            @(posedge clk);
            #1;
            reg_wr = 1'b0;
            drive_ev(14'h0);
            check_rd(VECS[i].chk, VECS[i].exp_rd, $sformatf("R%0d vec%0d", VECS[i].req, i));
            check_irq(VECS[i].exp_irq, $sformatf("R%0d vec%0d", VECS[i].req, i));
        end

        // R1: event sets raw regardless of mask, checked on a cleared bit
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h2C; reg_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        reg_wr = 1'b0;
        drive_ev(14'h0002);
        @(negedge clk);
        drive_ev(14'h0);
        check_rd(8'h20, 32'h0008_0202, "R1 win bit with mask off");
        check_rd(8'h24, 32'h0000_0000, "R3 nothing enabled");

        // R10: reset mid-run with state set
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h28; reg_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        reg_wr = 1'b0;
        @(negedge clk);
        check_irq(1'b1, "R8 before reset");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_rd(8'h20, 32'h0, "R10 raw after reset");
        check_rd(8'h2C, 32'h0, "R10 mask after reset");
        check_irq(1'b0, "R10 irq after reset");

        finish_run();
    end

endmodule